// File: doc/BRIEF.md
# Scaled FP32-to-FP8 Quantizer

This block is a streaming cast unit. Each cycle it can take one IEEE single-precision value and a single-precision scale factor. It multiplies the two exactly and rounds the product once into an 8-bit floating-point code. A one-bit format select, carried with each transfer, picks between two 8-bit encodings:

- The forward format (select = 0) has 4 exponent bits and suits activations and weights.
- The gradient format (select = 1) has 5 exponent bits and suits backward gradients, which need more range.

Transfers move on a valid/ready handshake. The result appears two cycles after acceptance unless the output is stalled.

The block also keeps the largest input magnitude accepted since the last clear. The magnitude is taken before scaling. Software reads this statistic to choose the next scale factor.

Top module: `fp8q_top`

## Requirements
- R1: With fmt_sel = 0 the code is sign, 4-bit exponent (bias 7), 3-bit mantissa; 1.0 encodes as 0x38, -2.5 as 0xC2, and the largest finite magnitude 448 as 0x7E.
- R2: With fmt_sel = 1 the code is sign, 5-bit exponent (bias 15), 2-bit mantissa; 1.0 encodes as 0x3C, -3.0 as 0xC2, 57344 as 0x7B.
- R3: The code represents in_data × scale rounded only once from the exact product, including FP32 subnormal operands (2^-127 × 2^127 gives 1.0).
- R4: Rounding is to nearest with ties to an even mantissa; a mantissa that rounds up past its maximum carries into the exponent (1.9375 gives 0x40 in the forward format).
- R5: A finite result whose rounded magnitude exceeds the format's largest finite value saturates to 0x7E/0xFE (forward) or 0x7B/0xFB (gradient) with the product's sign.
- R6: Results below the smallest normal are encoded as subnormals (exponent field 0; 2^-9 gives 0x01 forward, 2^-16 gives 0x01 gradient); magnitudes that round to zero give a zero code carrying the product's sign (0x00 or 0x80).
- R7: A NaN operand, or infinity times zero, produces the code 0x7F in both formats.
- R8: An infinite product (not times zero) gives 0x7C/0xFC in the gradient format and saturates to 0x7E/0xFE in the forward format.
- R9: in_ready is high exactly when out_valid is low or out_ready is high; while out_valid is high and out_ready low, out_code holds; an accepted value appears on the output two cycles later when not stalled.
- R10: stat_absmax (FP32 bits, sign 0) becomes, the cycle after each accepted non-NaN input, the larger of its old value and that input's magnitude; NaN inputs leave it unchanged.
- R11: stat_clear sets stat_absmax to zero on the next cycle, or to the magnitude of a non-NaN input accepted in the same cycle.
- R12: After reset out_valid is 0, in_ready is 1 and stat_absmax is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Block accepts the input this cycle |
| in_data | input | 32 | FP32 value to quantize |
| scale | input | 32 | FP32 scale factor applied to in_data |
| fmt_sel | input | 1 | 0 = forward format, 1 = gradient format |
| out_valid | output | 1 | out_code is valid |
| out_ready | input | 1 | Consumer takes out_code |
| out_code | output | 8 | Quantized 8-bit code |
| stat_clear | input | 1 | Synchronous clear of the magnitude statistic |
| stat_absmax | output | 32 | Largest accepted input magnitude, FP32 bits |

## Verification
The assertions check on every cycle that a stalled output holds its code, that no input is taken while the output is blocked, and that the stage flow keeps moving. They also check that the magnitude statistic never shrinks without a clear, that it always covers the last accepted non-NaN magnitude, and that an idle clear empties it. Code values cannot be checked by a property. Only the bench's scenarios show the exact rounding ties, the carry into the exponent, saturation thresholds, subnormal and signed-zero results and special-value mapping in both formats. These scenarios compare every output against a real-number model across a broad sweep of scaled inputs, with and without back-pressure.

// File: rtl/fp8q_pkg.sv
package fp8q_pkg;

    localparam int F32_W    = 32;
    localparam int F32_EW   = 8;
    localparam int F32_MW   = 23;
    localparam int F32_BIAS = 127;
    localparam int SIG_W    = F32_MW + 1;
    localparam int PROD_W   = 2 * SIG_W;
    localparam int EXP_W    = 12;
    localparam int F8_W     = 8;
    localparam int MAG_W    = F8_W - 1;
    localparam int SHIFT_W  = 64;
    localparam int SH_W     = $clog2(SHIFT_W);

    localparam logic [MAG_W-1:0] NAN_MAG = 7'h7F;

    typedef enum logic { FMT_FWD = 1'b0, FMT_GRAD = 1'b1 } fp8_fmt_e;

    typedef enum logic [1:0] {
        CLS_FIN  = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } val_cls_e;

    typedef struct packed {
        logic                    sign;
        val_cls_e                cls;
        fp8_fmt_e                fmt;
        logic signed [EXP_W-1:0] pexp;
        logic [PROD_W-1:0]       prod;
    } prod_t;

    function automatic int fmt_mant_bits(fp8_fmt_e f);
        return (f == FMT_FWD) ? 3 : 2;
    endfunction

    function automatic int fmt_bias(fp8_fmt_e f);
        return (f == FMT_FWD) ? 7 : 15;
    endfunction

    function automatic logic [MAG_W-1:0] fmt_max_mag(fp8_fmt_e f);
        return (f == FMT_FWD) ? 7'h7E : 7'h7B;
    endfunction

    function automatic logic [MAG_W-1:0] fmt_inf_mag(fp8_fmt_e f);
        return (f == FMT_FWD) ? 7'h7E : 7'h7C;
    endfunction

    function automatic val_cls_e f32_class(logic [F32_W-1:0] v);
        logic [F32_EW-1:0] ef;
        logic [F32_MW-1:0] fr;
        ef = v[F32_W-2:F32_MW];
        fr = v[F32_MW-1:0];
        if (&ef)           return (fr != '0) ? CLS_NAN : CLS_INF;
        else if (ef == '0 && fr == '0) return CLS_ZERO;
        else               return CLS_FIN;
    endfunction

    function automatic logic [SIG_W-1:0] f32_sig(logic [F32_W-1:0] v);
        return {(v[F32_W-2:F32_MW] != '0), v[F32_MW-1:0]};
    endfunction

    function automatic logic signed [EXP_W-1:0] f32_exp(logic [F32_W-1:0] v);
        logic signed [EXP_W-1:0] r;
        if (v[F32_W-2:F32_MW] == '0)
            r = EXP_W'(1 - F32_BIAS);
        else
            r = $signed({{(EXP_W-F32_EW){1'b0}}, v[F32_W-2:F32_MW]}) - EXP_W'(F32_BIAS);
        return r;
    endfunction

    function automatic int lead_one(logic [PROD_W-1:0] p);
        int r;
        r = 0;
        for (int i = 0; i < PROD_W; i++)
            if (p[i]) r = i;
        return r;
    endfunction

endpackage

// File: rtl/fp8q_mul_stage.sv
module fp8q_mul_stage
    import fp8q_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    input  logic             load_i,
    input  logic [F32_W-1:0] x_i,
    input  logic [F32_W-1:0] scale_i,
    input  fp8_fmt_e         fmt_i,
    output logic             valid_o,
    output prod_t            prod_o
);

    val_cls_e cls_x, cls_s, cls_p;
    prod_t    next_p;

    always_comb begin
        cls_x = f32_class(x_i);
        cls_s = f32_class(scale_i);
        if (cls_x == CLS_NAN || cls_s == CLS_NAN ||
            (cls_x == CLS_INF && cls_s == CLS_ZERO) ||
            (cls_s == CLS_INF && cls_x == CLS_ZERO))
            cls_p = CLS_NAN;
        else if (cls_x == CLS_INF || cls_s == CLS_INF)
            cls_p = CLS_INF;
        else if (cls_x == CLS_ZERO || cls_s == CLS_ZERO)
            cls_p = CLS_ZERO;
        else
            cls_p = CLS_FIN;

        next_p.sign = x_i[F32_W-1] ^ scale_i[F32_W-1];
        next_p.cls  = cls_p;
        next_p.fmt  = fmt_i;
        next_p.prod = PROD_W'(f32_sig(x_i)) * PROD_W'(f32_sig(scale_i));
        next_p.pexp = f32_exp(x_i) + f32_exp(scale_i) - EXP_W'(2 * F32_MW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            prod_o  <= '0;
        end else if (adv_i) begin
            valid_o <= load_i;
            prod_o  <= next_p;
        end
    end

endmodule

// File: rtl/fp8q_round_stage.sv
module fp8q_round_stage
    import fp8q_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            adv_i,
    input  logic            valid_i,
    input  prod_t           prod_i,
    output logic            valid_o,
    output logic [F8_W-1:0] code_o
);

    int                      mb;
    int                      bias;
    logic signed [EXP_W-1:0] lead;
    logic signed [EXP_W-1:0] e_val;
    logic signed [EXP_W-1:0] e_min;
    logic signed [EXP_W-1:0] q_exp;
    logic signed [EXP_W-1:0] shamt;
    logic signed [EXP_W-1:0] neg_sh;
    logic signed [EXP_W-1:0] base;
    logic [SH_W-1:0]         sh;
    logic [SHIFT_W-1:0]      wide;
    logic [SHIFT_W-1:0]      mask;
    logic [SHIFT_W-1:0]      rem;
    logic [SHIFT_W-1:0]      half;
    logic [SHIFT_W-1:0]      nq;
    logic [SHIFT_W-1:0]      code_w;
    logic                    round_up;
    logic [F8_W-1:0]         next_code;

    always_comb begin
        mb     = fmt_mant_bits(prod_i.fmt);
        bias   = fmt_bias(prod_i.fmt);
        lead   = EXP_W'(lead_one(prod_i.prod));
        e_val  = lead + prod_i.pexp;
        e_min  = EXP_W'(1 - bias);
        q_exp  = (e_val < e_min) ? e_min : e_val;
        shamt  = q_exp - $signed(EXP_W'(mb)) - prod_i.pexp;
        neg_sh = -shamt;
        wide   = {{(SHIFT_W-PROD_W){1'b0}}, prod_i.prod};
        sh     = '0;
        mask   = '0;
        rem    = '0;
        half   = '0;
        if (shamt < 12'sd1) begin
            nq       = wide << neg_sh;
            round_up = 1'b0;
        end else begin
            sh       = (shamt > 12'sd63) ? SH_W'(63) : shamt[SH_W-1:0];
            mask     = (SHIFT_W'(1) << sh) - SHIFT_W'(1);
            rem      = wide & mask;
            half     = SHIFT_W'(1) << (sh - SH_W'(1));
            nq       = wide >> sh;
            round_up = (rem > half) || (rem == half && nq[0]);
        end
        base   = q_exp + $signed(EXP_W'(bias)) - 12'sd1;
        code_w = (SHIFT_W'(base) << mb) + nq + SHIFT_W'(round_up);

        unique case (prod_i.cls)
            CLS_NAN:  next_code = {1'b0, NAN_MAG};
            CLS_INF:  next_code = {prod_i.sign, fmt_inf_mag(prod_i.fmt)};
            CLS_ZERO: next_code = {prod_i.sign, {MAG_W{1'b0}}};
            default: begin
                if (code_w > SHIFT_W'(fmt_max_mag(prod_i.fmt)))
                    next_code = {prod_i.sign, fmt_max_mag(prod_i.fmt)};
                else
                    next_code = {prod_i.sign, code_w[MAG_W-1:0]};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            code_o  <= '0;
        end else if (adv_i) begin
            valid_o <= valid_i;
            code_o  <= next_code;
        end
    end

endmodule

// File: rtl/fp8q_absmax.sv
module fp8q_absmax
    import fp8q_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             take_i,
    input  logic [F32_W-2:0] mag_i,
    output logic [F32_W-1:0] max_o
);

    localparam logic [F32_W-2:0] INF_MAG = {{F32_EW{1'b1}}, {F32_MW{1'b0}}};

    logic [F32_W-2:0] max_q;
    logic             is_nan;

    assign is_nan = mag_i > INF_MAG;
    assign max_o  = {1'b0, max_q};

    always_ff @(posedge clk) begin
        if (rst)
            max_q <= '0;
        else if (clear_i)
            max_q <= (take_i && !is_nan) ? mag_i : '0;
        else if (take_i && !is_nan && mag_i > max_q)
            max_q <= mag_i;
    end

    // R10: statistic never shrinks without a clear
    a_r10_absmax_monotone: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> (max_o >= $past(max_o)));

    // R10: statistic covers every accepted non-NaN magnitude
    a_r10_absmax_covers: assert property (@(posedge clk) disable iff (rst)
        (take_i && !is_nan) |=> (max_o[F32_W-2:0] >= $past(mag_i)));

    // R11: an idle clear empties the statistic
    a_r11_clear_idle: assert property (@(posedge clk) disable iff (rst)
        (clear_i && !take_i) |=> (max_o == '0));

endmodule

// File: rtl/fp8q_top.sv
module fp8q_top
    import fp8q_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    input  logic [31:0] scale,
    input  logic        fmt_sel,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_code,
    input  logic        stat_clear,
    output logic [31:0] stat_absmax
);

    logic  adv;
    logic  fire;
    logic  s1_valid;
    prod_t s1_prod;

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;
    assign fire     = in_valid && in_ready;

    fp8q_mul_stage u_mul (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (adv),
        .load_i  (fire),
        .x_i     (in_data),
        .scale_i (scale),
        .fmt_i   (fp8_fmt_e'(fmt_sel)),
        .valid_o (s1_valid),
        .prod_o  (s1_prod)
    );

    fp8q_round_stage u_round (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (adv),
        .valid_i (s1_valid),
        .prod_i  (s1_prod),
        .valid_o (out_valid),
        .code_o  (out_code)
    );

    fp8q_absmax u_absmax (
        .clk     (clk),
        .rst     (rst),
        .clear_i (stat_clear),
        .take_i  (fire),
        .mag_i   (in_data[30:0]),
        .max_o   (stat_absmax)
    );

    // R9: blocked output holds its code
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));

    // R9: nothing accepted while the output is blocked
    a_r9_no_take_blocked: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R9: a product in the first stage reaches the output when the sink is ready
    a_r9_stage_flow: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && out_ready) |=> out_valid);

endmodule

// File: tb/tb_fp8q_top.sv
`timescale 1ns/1ps
module tb_fp8q_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_data;
    logic [31:0] scale;
    logic        fmt_sel;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_code;
    logic        stat_clear;
    logic [31:0] stat_absmax;

    always #2 clk = ~clk;

    fp8q_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .scale(scale), .fmt_sel(fmt_sel),
        .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
        .stat_clear(stat_clear), .stat_absmax(stat_absmax)
    );

    int          n_tests = 0;
    int          n_fail  = 0;
    int          cyc     = 0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];
    int          acc_q[$];
    string       cur_tag = "";
    bit          lat_check = 1'b1;
    bit          stall_mode = 1'b0;
    logic [7:0]  lf = 8'h5A;
    logic [31:0] model_max = '0;
    bit          hold_pending = 1'b0;
    logic [7:0]  hold_code;
    logic [31:0] seed = 32'h1234_5678;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    function automatic real pow2(int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else        for (int i = 0; i < -k; i++) r = r / 2.0;
        return r;
    endfunction

    function automatic real f32_real(logic [31:0] v);
        int ef = int'(v[30:23]);
        real frac = real'(v[22:0]);
        if (ef == 0) return frac * pow2(-149);
        return (frac + 8388608.0) * pow2(ef - 150);
    endfunction

    function automatic real dec8(int c, bit f);
        int mb = f ? 2 : 3;
        int bias = f ? 15 : 7;
        int ef = c >> mb;
        int mt = c & ((1 << mb) - 1);
        if (ef == 0) return real'(mt) * pow2(1 - bias - mb);
        return real'(mt + (1 << mb)) * pow2(ef - bias - mb);
    endfunction

    function automatic bit is_nan32(logic [31:0] v);
        return (&v[30:23]) && (v[22:0] != 0);
    endfunction
    function automatic bit is_inf32(logic [31:0] v);
        return (&v[30:23]) && (v[22:0] == 0);
    endfunction
    function automatic bit is_zero32(logic [31:0] v);
        return v[30:0] == 0;
    endfunction

    function automatic logic [7:0] ref_code(logic [31:0] x, logic [31:0] s, bit f);
        logic sg = x[31] ^ s[31];
        real a, mid;
        int maxc = f ? 123 : 126;
        int lo = 0;
        int r;
        if (is_nan32(x) || is_nan32(s) || (is_inf32(x) && is_zero32(s)) ||
            (is_inf32(s) && is_zero32(x)))
            return 8'h7F;
        if (is_inf32(x) || is_inf32(s))
            return {sg, f ? 7'h7C : 7'h7E};
        a = f32_real({1'b0, x[30:0]}) * f32_real({1'b0, s[30:0]});
        for (int c = 0; c <= maxc; c++) if (dec8(c, f) <= a) lo = c;
        if (lo == maxc) r = maxc;
        else begin
            mid = (dec8(lo, f) + dec8(lo + 1, f)) / 2.0;
            if (a < mid)      r = lo;
            else if (a > mid) r = lo + 1;
            else              r = (lo % 2 == 0) ? lo : lo + 1;
        end
        return {sg, 7'(r)};
    endfunction

    // monitor: samples away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            check(stat_absmax == model_max, "R10/R11 absmax", stat_absmax, model_max);
            if (hold_pending) begin
                check(out_valid && out_code == hold_code, "R9 stall hold",
                      {23'b0, out_valid, out_code}, {24'h1, hold_code});
                hold_pending = 1'b0;
            end
            if (out_valid && !out_ready) begin
                check(!in_ready, "R9 in_ready when blocked", 32'(in_ready), 32'd0);
                hold_pending = 1'b1;
                hold_code    = out_code;
            end else begin
                check(in_ready, "R9 in_ready when free", 32'(in_ready), 32'd1);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 spurious output", 32'(out_code), 32'hFFFF_FFFF);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string      t = tag_q.pop_front();
                    automatic int         ac = acc_q.pop_front();
                    check(out_code == e, t, 32'(out_code), 32'(e));
                    if (lat_check)
                        check(cyc - ac == 2, "R9 latency", 32'(cyc - ac), 32'd2);
                end
            end
            if (in_valid && in_ready) begin
                exp_q.push_back(ref_code(in_data, scale, fmt_sel));
                tag_q.push_back(cur_tag);
                acc_q.push_back(cyc);
            end
            if (stat_clear) model_max = '0;
            if (in_valid && in_ready && !is_nan32(in_data) && {1'b0, in_data[30:0]} > model_max)
                model_max = {1'b0, in_data[30:0]};
        end
    end

    always @(posedge clk) begin
        #1;
        if (stall_mode) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            out_ready = lf[0] | lf[2];
        end
    end

    task automatic send(logic [31:0] x, logic [31:0] s, bit f, string tag);
        in_valid = 1'b1;
        in_data  = x;
        scale    = s;
        fmt_sel  = f;
        cur_tag  = tag;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] rnd32();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic send_random(string tag);
        logic [31:0] r1 = rnd32();
        logic [31:0] r2 = rnd32();
        logic [31:0] x = {r1[31], 8'(100 + (r1[30:23] % 56)), r2[22:0]};
        logic [31:0] s;
        case (r2[26:24])
            3'd0: s = 32'h3F80_0000;
            3'd1: s = 32'h3F00_0000;
            3'd2: s = 32'h4040_0000;
            3'd3: s = 32'h3B80_0000;
            3'd4: s = 32'h447A_0000;
            3'd5: s = 32'h3D80_0000;
            3'd6: s = 32'h4780_0000;
            default: s = 32'hBF80_0000;
        endcase
        send(x, s, r2[27], tag);
    endtask

    localparam logic [31:0] ONE = 32'h3F80_0000;

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0; scale = '0; fmt_sel = 1'b0;
        out_ready = 1'b1; stat_clear = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check(!out_valid, "R12 out_valid after reset", 32'(out_valid), 32'd0);
        check(in_ready, "R12 in_ready after reset", 32'(in_ready), 32'd1);
        check(stat_absmax == 0, "R12 absmax after reset", stat_absmax, 32'd0);
        @(posedge clk); #1;

        // R1: forward format basics (0x38, 0xC2, 0x7E)
        send(ONE,          ONE, 1'b0, "R1 fwd 1.0");
        send(32'hC020_0000, ONE, 1'b0, "R1 fwd -2.5");
        send(32'h43E0_0000, ONE, 1'b0, "R1 fwd 448");
        // R2: gradient format basics (0x3C, 0xC2, 0x7B)
        send(ONE,          ONE, 1'b1, "R2 grad 1.0");
        send(32'hC040_0000, ONE, 1'b1, "R2 grad -3.0");
        send(32'h4760_0000, ONE, 1'b1, "R2 grad 57344");
        // R3: scaling, single rounding, subnormal operand
        send(32'h4040_0000, 32'h3F00_0000, 1'b0, "R3 3.0*0.5");
        send(32'h0040_0000, 32'h7F00_0000, 1'b0, "R3 subnormal*2^127");
        send(32'h3F88_0001, ONE, 1'b0, "R3 just above tie");
        // R4: ties to even and carry into exponent
        send(32'h3F88_0000, ONE, 1'b0, "R4 tie down 1.0625");
        send(32'h3F98_0000, ONE, 1'b0, "R4 tie up 1.1875");
        send(32'h3FF8_0000, ONE, 1'b0, "R4 carry 1.9375");
        send(32'h43E8_0000, ONE, 1'b0, "R4 tie 464 to 448");
        // R5: saturation
        send(32'h43FA_0000, ONE, 1'b0, "R5 fwd 500");
        send(32'h43F0_0000, ONE, 1'b0, "R5 fwd 480");
        send(32'hC974_2400, ONE, 1'b0, "R5 fwd -1e6");
        send(32'h42C8_0000, 32'h4100_0000, 1'b0, "R5 fwd 100*8");
        send(32'h476A_6000, ONE, 1'b1, "R5 grad 60000");
        send(32'h4770_0000, ONE, 1'b1, "R5 grad 61440");
        // R6: subnormals and signed zero
        send(32'h3B00_0000, ONE, 1'b0, "R6 fwd 2^-9");
        send(32'h3A80_0000, ONE, 1'b0, "R6 fwd 2^-10 tie");
        send(32'h3AC0_0000, ONE, 1'b0, "R6 fwd 1.5*2^-10");
        send(32'hB580_0000, ONE, 1'b0, "R6 fwd -2^-20");
        send(32'h3780_0000, ONE, 1'b1, "R6 grad 2^-16");
        send(32'h8000_0000, ONE, 1'b1, "R6 -0.0");
        // R7: NaN cases
        send(32'h7FC0_0000, ONE, 1'b0, "R7 NaN in");
        send(ONE, 32'hFFC0_0001, 1'b1, "R7 NaN scale");
        send(32'h7F80_0000, 32'h0000_0000, 1'b1, "R7 inf*0");
        // R8: infinite products
        send(32'h7F80_0000, ONE, 1'b1, "R8 grad +inf");
        send(32'hFF80_0000, ONE, 1'b0, "R8 fwd -inf");
        drain();

        // R11: clear idle and clear with accept
        stat_clear = 1'b1; @(posedge clk); #1; stat_clear = 1'b0;
        send(32'h4000_0000, ONE, 1'b0, "R1 fwd 2.0");
        stat_clear = 1'b1;
        send(32'h3F00_0000, ONE, 1'b0, "R11 clear with accept");
        stat_clear = 1'b0;
        send(32'h7FC0_0000, ONE, 1'b0, "R10 NaN ignored");
        stat_clear = 1'b1;
        send(32'hFFC0_0000, ONE, 1'b1, "R11 clear with NaN");
        stat_clear = 1'b0;
        drain();

        // R3: random sweep in both formats
        for (int i = 0; i < 400; i++) send_random("R3 sweep");
        drain();

        // R9: back-pressure phase
        lat_check  = 1'b0;
        stall_mode = 1'b1;
        for (int i = 0; i < 150; i++) send_random("R9 sweep under stall");
        stall_mode = 1'b0;
        @(posedge clk); #1;
        out_ready = 1'b1;
        drain();
        repeat (3) @(posedge clk);
        #1 lat_check = 1'b1;
        send(ONE, ONE, 1'b1, "R2 grad 1.0 after stall");
        drain();
        check(exp_q.size() == 0, "R9 all outputs delivered", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule